// File: doc/BRIEF.md
# E3 Frame-Loss Supervisor

This block sits behind the bit-alignment search logic of an E3 receiver and decides, frame by frame, whether the link is out of frame (OOF) and whether that state has lasted long enough to count as loss of frame (LOF). The search logic supplies three inputs. The first is a strobe once per received frame, with a flag that marks a bad framing pattern. The second is a one-cycle pulse when alignment has been regained. The third is a free-running 1 ms tick. The supervisor turns these into live OOF and LOF levels and drives the transmit far-end-receive-failure request.

Every entry to or exit from OOF, and every declaration or clearing of LOF, is a change-of-condition event. When its enable bit is set, an event latches a status bit and pulls the active-low interrupt pin. Software reads the latched bits, which clears them, through a byte-wide register port. The same port selects the LOF persistence window, either 1 ms or 3 ms, and shows the live condition levels together with the loss-of-signal, alarm-indication and received far-end-failure inputs passed in from the line side.

Top module: `e3fl_supervisor`

## Requirements
- R1: After reset, oof, lof and ferf_req are 0, irq_n is 1, the enable register (0x12) reads 0x00 and the window-select bit reads 0.
- R2: The edge that samples the fourth errored frame strobe in an unbroken run sets oof. A frame strobe without the error flag restarts the count, and while oof is 1 further strobes have no effect.
- R3: While oof is 1, lof rises on the edge that samples the Nth tick counted after OOF entry. N is 1 when bit 7 of register 0x11 is 0 and 3 when it is 1. A tick on the OOF entry edge is not counted. Once set, lof stays 1 until realignment, and lof is never 1 while oof is 0.
- R4: A realign pulse clears oof, lof, the errored-frame count and the tick count on the edge that samples it. It takes priority over an errored frame strobe in the same cycle.
- R5: ferf_req is 1 exactly while oof is 1.
- R6: When bit 2 of 0x12 is 1, each rise or fall of lof sets bit 2 of the interrupt status register 0x13 on the same edge.
- R7: When bit 3 of 0x12 is 1, each rise or fall of oof sets bit 3 of 0x13 on the same edge.
- R8: An event whose enable bit is 0 leaves 0x13 unchanged and leaves irq_n high.
- R9: irq_n is 0 while any bit of 0x13 is set together with its enable bit. A read of 0x13 returns the latched bits and clears them. If an event lands on the same edge as the read, the event wins.
- R10: A read returns its data on reg_rdata one cycle after reg_rd. Register 0x11 holds the window-select bit (bit 7, read/write) and read-only live levels: lof (bit 6), oof (bit 5), los_in (bit 4), ais_in (bit 3) and rx_ferf_in (bit 1). Register 0x12 keeps bits 4..0 writable and reads bits 7..5 as 0. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per received E3 frame |
| frame_err | input | 1 | Framing pattern of this frame was wrong (qualified by frame_stb) |
| realign | input | 1 | One-cycle pulse: alignment regained |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| los_in | input | 1 | Live loss-of-signal level, shown in 0x11 |
| ais_in | input | 1 | Live alarm-indication level, shown in 0x11 |
| rx_ferf_in | input | 1 | Live received far-end-failure level, shown in 0x11 |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_n | output | 1 | Active-low interrupt request |
| oof | output | 1 | Live out-of-frame level |
| lof | output | 1 | Live loss-of-frame level |
| ferf_req | output | 1 | Request to send far-end-receive-failure |

## Verification
oof, lof, ferf_req, the latched status bits and irq_n are all updated by the clock edge that samples the causing strobe, tick or realign pulse, so they are due one edge after the stimulus. reg_rdata is due one edge after reg_rd. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each expected value therefore refers to a single known edge. Window lengths are checked one tick short of the limit and again at the limit.

// File: rtl/e3fl_pkg.sv
package e3fl_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;
    localparam int IEN_W  = 5;

    localparam logic [REG_AW-1:0] ADDR_CFG = 8'h11;
    localparam logic [REG_AW-1:0] ADDR_IEN = 8'h12;
    localparam logic [REG_AW-1:0] ADDR_IST = 8'h13;

    // configuration/status byte positions
    localparam int CFG_SEL  = 7;
    localparam int CFG_LOF  = 6;
    localparam int CFG_OOF  = 5;
    localparam int CFG_LOS  = 4;
    localparam int CFG_AIS  = 3;
    localparam int CFG_FERF = 1;

    // enable byte positions (status byte reuses OOF/LOF positions)
    localparam int EN_COFA = 4;
    localparam int EN_OOF  = 3;
    localparam int EN_LOF  = 2;
    localparam int EN_LOS  = 1;
    localparam int EN_AIS  = 0;

    typedef struct packed {
        logic oof;
        logic lof;
        logic los;
        logic ais;
        logic rx_ferf;
    } line_stat_t;

    typedef struct packed {
        logic oof_chg;
        logic lof_chg;
    } cond_evt_t;

    function automatic logic [REG_DW-1:0] cfg_byte(line_stat_t st, logic sel);
        logic [REG_DW-1:0] b;
        b           = '0;
        b[CFG_SEL]  = sel;
        b[CFG_LOF]  = st.lof;
        b[CFG_OOF]  = st.oof;
        b[CFG_LOS]  = st.los;
        b[CFG_AIS]  = st.ais;
        b[CFG_FERF] = st.rx_ferf;
        return b;
    endfunction

    function automatic logic [REG_DW-1:0] ist_byte(cond_evt_t ist);
        logic [REG_DW-1:0] b;
        b         = '0;
        b[EN_OOF] = ist.oof_chg;
        b[EN_LOF] = ist.lof_chg;
        return b;
    endfunction

endpackage

// File: rtl/e3fl_oof_detect.sv
module e3fl_oof_detect #(
    parameter int ERR_FRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic frame_err,
    input  logic realign,
    output logic oof_q,
    output logic oof_evt
);
    localparam int CW = $clog2(ERR_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(ERR_FRAMES - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          oof_d;

    always_comb begin
        cnt_d = cnt_q;
        oof_d = oof_q;
        if (realign) begin
            cnt_d = '0;
            oof_d = 1'b0;
        end else if (!oof_q && frame_stb) begin
            if (!frame_err) begin
                cnt_d = '0;
            end else if (cnt_q == LAST) begin
                cnt_d = '0;
                oof_d = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    assign oof_evt = oof_d ^ oof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            oof_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            oof_q <= oof_d;
        end
    end
endmodule

// File: rtl/e3fl_lof_timer.sv
module e3fl_lof_timer #(
    parameter int SHORT_MS = 1,
    parameter int LONG_MS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic oof,
    input  logic realign,
    input  logic tick,
    input  logic long_sel,
    output logic lof_q,
    output logic lof_evt
);
    localparam int MAXW = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int TW   = $clog2(MAXW + 1);

    logic [TW-1:0] tcnt_q, tcnt_d, limit;
    logic          lof_d;

    assign limit = long_sel ? TW'(LONG_MS) : TW'(SHORT_MS);

    always_comb begin
        tcnt_d = tcnt_q;
        lof_d  = lof_q;
        if (realign || !oof) begin
            tcnt_d = '0;
            lof_d  = 1'b0;
        end else if (!lof_q && tick) begin
            if ((tcnt_q + TW'(1)) >= limit) begin
                tcnt_d = '0;
                lof_d  = 1'b1;
            end else begin
                tcnt_d = tcnt_q + TW'(1);
            end
        end
    end

    assign lof_evt = lof_d ^ lof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
            lof_q  <= 1'b0;
        end else begin
            tcnt_q <= tcnt_d;
            lof_q  <= lof_d;
        end
    end
endmodule

// File: rtl/e3fl_regs.sv
module e3fl_regs
    import e3fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_DW-1:0] wdata,
    input  line_stat_t        stat,
    input  cond_evt_t         evt,
    output logic [REG_DW-1:0] rdata,
    output logic              long_sel,
    output logic [IEN_W-1:0]  ien_q,
    output cond_evt_t         ist_q,
    output logic              irq_n
);
    cond_evt_t set_v, ist_d;
    logic      clr;
    logic      unused_wbits;

    assign unused_wbits = ^wdata[CFG_SEL-1:IEN_W];

    assign set_v.oof_chg = evt.oof_chg & ien_q[EN_OOF];
    assign set_v.lof_chg = evt.lof_chg & ien_q[EN_LOF];
    assign clr           = rd && (addr == ADDR_IST);
    assign ist_d         = (clr ? cond_evt_t'('0) : ist_q) | set_v;

    assign irq_n = ~((ist_q.oof_chg & ien_q[EN_OOF]) |
                     (ist_q.lof_chg & ien_q[EN_LOF]));

    always_ff @(posedge clk) begin
        if (rst) begin
            long_sel <= 1'b0;
            ien_q    <= '0;
            ist_q    <= '0;
            rdata    <= '0;
        end else begin
            ist_q <= ist_d;
            if (wr && addr == ADDR_CFG) long_sel <= wdata[CFG_SEL];
            if (wr && addr == ADDR_IEN) ien_q    <= wdata[IEN_W-1:0];
            if (rd) begin
                case (addr)
                    ADDR_CFG: rdata <= cfg_byte(stat, long_sel);
                    ADDR_IEN: rdata <= REG_DW'(ien_q);
                    ADDR_IST: rdata <= ist_byte(ist_q);
                    default:  rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/e3fl_supervisor.sv
module e3fl_supervisor
    import e3fl_pkg::*;
#(
    parameter int ERR_FRAMES = 4,
    parameter int SHORT_MS   = 1,
    parameter int LONG_MS    = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_stb,
    input  logic        frame_err,
    input  logic        realign,
    input  logic        tick_1ms,
    input  logic        los_in,
    input  logic        ais_in,
    input  logic        rx_ferf_in,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq_n,
    output logic        oof,
    output logic        lof,
    output logic        ferf_req
);
    logic             oof_w, lof_w, long_sel_w;
    cond_evt_t        evt_w, ist_w;
    line_stat_t       stat_w;
    logic [IEN_W-1:0] ien_w;

    e3fl_oof_detect #(.ERR_FRAMES(ERR_FRAMES)) oof_i (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_err(frame_err),
        .realign(realign), .oof_q(oof_w), .oof_evt(evt_w.oof_chg)
    );

    e3fl_lof_timer #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) lof_i (
        .clk(clk), .rst(rst), .oof(oof_w), .realign(realign), .tick(tick_1ms),
        .long_sel(long_sel_w), .lof_q(lof_w), .lof_evt(evt_w.lof_chg)
    );

    assign stat_w = '{oof: oof_w, lof: lof_w, los: los_in, ais: ais_in,
                      rx_ferf: rx_ferf_in};

    e3fl_regs regs_i (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .stat(stat_w), .evt(evt_w), .rdata(reg_rdata),
        .long_sel(long_sel_w), .ien_q(ien_w), .ist_q(ist_w), .irq_n(irq_n)
    );

    assign oof      = oof_w;
    assign lof      = lof_w;
    assign ferf_req = oof_w;
endmodule

// File: rtl/e3fl_supervisor_chk.sv
module e3fl_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic       frame_err,
    input logic       realign,
    input logic       reg_wr,
    input logic       oof,
    input logic       lof,
    input logic       irq_n,
    input logic [4:0] ien,
    input logic [1:0] ist
);
    // OOF only rises after an errored frame strobe that realign did not override
    assert_oof_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(oof) |-> $past(frame_stb && frame_err && !realign));

    // LOF never stands without OOF
    assert_lof_needs_oof_R3: assert property (@(posedge clk) disable iff (rst)
        lof |-> oof);

    // realign clears both conditions on its edge
    assert_realign_clears_R4: assert property (@(posedge clk) disable iff (rst)
        realign |=> (!oof && !lof));

    // an enabled OOF change latches its status bit
    assert_oof_latch_R7: assert property (@(posedge clk) disable iff (rst)
        ((oof != $past(oof)) && $past(ien[3])) |-> ist[1]);

    // the pin only drops on a condition change or a register write
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ((oof != $past(oof)) || (lof != $past(lof)) || $past(reg_wr)));
endmodule

bind e3fl_supervisor e3fl_supervisor_chk chk_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_err(frame_err),
    .realign(realign), .reg_wr(reg_wr), .oof(oof), .lof(lof), .irq_n(irq_n),
    .ien(ien_w), .ist(ist_w)
);

// File: tb/e3fl_supervisor_tb.sv
module e3fl_supervisor_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 0, frame_err = 0, realign = 0, tick_1ms = 0;
    logic       los_in = 0, ais_in = 0, rx_ferf_in = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_rdata;
    logic       irq_n, oof, lof, ferf_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    e3fl_supervisor dut_i (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_err(frame_err),
        .realign(realign), .tick_1ms(tick_1ms), .los_in(los_in), .ais_in(ais_in),
        .rx_ferf_in(rx_ferf_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .oof(oof), .lof(lof), .ferf_req(ferf_req)
    );

    // {stb, err, realign, tick, exp_oof, exp_lof}; window select = 1 ms
    localparam logic [5:0] VEC [17] = '{
        6'b110000, 6'b110000, 6'b110000, 6'b100000,
        6'b110000, 6'b110000, 6'b110000, 6'b110010,
        6'b000111, 6'b110011, 6'b001000, 6'b111000,
        6'b110000, 6'b110000, 6'b110000, 6'b110010,
        6'b001000
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic e, input logic r, input logic t);
        frame_stb = s; frame_err = e; realign = r; tick_1ms = t;
        @(posedge clk); #1;
        frame_stb = 0; frame_err = 0; realign = 0; tick_1ms = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1; reg_wr = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1;
        @(posedge clk); #1; reg_rd = 0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic errs4();
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oof", {7'd0, oof}, 8'h00);
        chk("R1 lof", {7'd0, lof}, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 ferf_req", {7'd0, ferf_req}, 8'h00);
        rd(8'h12, d); chk("R1 enables", d, 8'h00);
        rd(8'h11, d); chk("R1 cfg", d, 8'h00);

        // table walk: R2, R3, R4, R5
        for (int i = 0; i < 17; i++) begin
            cyc(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            chk($sformatf("R2/R4 oof vec%0d", i), {7'd0, oof}, {7'd0, VEC[i][1]});
            chk($sformatf("R3/R4 lof vec%0d", i), {7'd0, lof}, {7'd0, VEC[i][0]});
            chk($sformatf("R5 ferf vec%0d", i), {7'd0, ferf_req}, {7'd0, VEC[i][1]});
        end

        // R10 register map
        wr(8'h12, 8'hFF);
        rd(8'h12, d); chk("R10 enable readback", d, 8'h1F);
        chk("R9 no pending", {7'd0, irq_n}, 8'h01);
        los_in = 1; rx_ferf_in = 1;
        wr(8'h11, 8'hFF);
        rd(8'h11, d); chk("R10 cfg live", d, 8'h92);
        rd(8'h20, d); chk("R10 unused addr", d, 8'h00);

        // R3 3 ms window, R6/R7/R9 interrupts
        wr(8'h12, 8'h0C);
        errs4();
        chk("R7 oof set", {7'd0, oof}, 8'h01);
        chk("R9 irq on oof", {7'd0, irq_n}, 8'h00);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        chk("R3 lof not before 3 ticks", {7'd0, lof}, 8'h00);
        cyc(0, 0, 0, 1);
        chk("R3 lof at 3rd tick", {7'd0, lof}, 8'h01);
        rd(8'h13, d); chk("R6 R7 status", d, 8'h0C);
        chk("R9 irq released", {7'd0, irq_n}, 8'h01);
        rd(8'h13, d); chk("R9 status cleared", d, 8'h00);
        rd(8'h11, d); chk("R10 cfg both", d, 8'hF2);
        cyc(0, 0, 1, 0);
        chk("R4 clear oof", {7'd0, oof}, 8'h00);
        chk("R4 clear lof", {7'd0, lof}, 8'h00);
        chk("R9 irq on clear", {7'd0, irq_n}, 8'h00);
        rd(8'h13, d); chk("R6 clear event", d, 8'h0C);

        // R8 disabled events
        wr(8'h12, 8'h00);
        errs4();
        chk("R8 oof still tracked", {7'd0, oof}, 8'h01);
        chk("R8 irq stays high", {7'd0, irq_n}, 8'h01);
        rd(8'h13, d); chk("R8 no status", d, 8'h00);
        cyc(0, 0, 1, 0);

        // R6 LOF-only enable with 1 ms window
        wr(8'h11, 8'h00);
        wr(8'h12, 8'h04);
        errs4();
        chk("R8 oof disabled irq", {7'd0, irq_n}, 8'h01);
        cyc(0, 0, 0, 1);
        chk("R3 lof 1ms", {7'd0, lof}, 8'h01);
        chk("R6 irq on lof", {7'd0, irq_n}, 8'h00);
        rd(8'h13, d); chk("R6 lof only", d, 8'h04);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule